// File: doc/BRIEF.md
# Multi-Source Tick Timer

This block is a free-running up-counter behind a small word-addressed register bus. Software picks where the count tick comes from: every bus-clock cycle, a slow tick of about 32 kHz, or an oscillator tick. The oscillator tick first passes an enable gate and a 4-bit pre-divider of its own. Whichever source is chosen then goes through a common 12-bit main divider before it advances the counter. Every tick input is a single-cycle enable pulse that is synchronous to the bus clock.

A status flag records each return of the counter to zero. Software clears the flag by writing a one to it. A self-clearing soft-reset bit returns every register and the counter to zero. A small control state machine steers the soft reset. In ST_RUN, bus writes are accepted. A control write with the soft-reset bit set takes the transition RUN_TO_SRST into ST_SRST. The machine stays in ST_SRST for a fixed number of bus cycles and ignores all writes there. When the hold counter expires, it takes the transition SRST_TO_RUN back to ST_RUN.

The counter width and the restart value are parameters. With the defaults, the counter is 32 bits and the restart value is all ones.

Top module: `tick_timer`

## Requirements
- R1: After reset, every readable word returns 0 and the counter does not move.
- R2: The control word is at byte 0x00, with these fields:
  - enable at bit 0
  - source select at bits [8:6]
  - mode at bit 9 (1 = wrap freely, 0 = restart)
  - oscillator-path enable at bit 10
  - soft reset at bit 15

  The prescaler word is at 0x04, with the main divider in bits [11:0] and the oscillator divider in bits [15:12]. The status word is at 0x08, with the rollover flag at bit 5. The counter is at 0x24 and is read-only. All other bits read 0. Words 0x0C to 0x20 read 0, and writes to them are ignored.
- R3: The counter never advances while the enable bit is 0.
- R4: The source codes are:
  - 3'b001: a tick on every bus cycle
  - 3'b100: one tick per `tick_slow` pulse
  - 3'b101: the divided oscillator tick

  Any other code stops counting.
- R5: The oscillator source ticks only while bit 10 is 1. It yields one tick per (oscillator divider + 1) `tick_osc` pulses.
- R6: The main divider applies to the selected source, after the oscillator pre-divider. The counter advances once per (main divider + 1) source ticks.
- R7: Both divider counters restart from zero on a control write that raises the enable bit or changes the source code. The first count after such a write therefore takes a full divider period.
- R8: In free-run mode, the counter wraps from all ones to 0. In restart mode, it returns to 0 after holding the restart value; it also wraps at all ones.
- R9: Each return of the counter to 0 by counting sets the rollover flag. Writing 1 to status bit 5 clears it, but a rollover in the same cycle wins over the clear.
- R10: Writing 1 to control bit 15 zeroes all registers and the counter. Bit 15 then reads 1 for exactly 4 cycles, and every bus write in that window is ignored.
- R11: A read is accepted in the cycle `bus_rd` is high. `bus_rdata` presents the word's value from that cycle on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_slow | input | 1 | Slow (32 kHz) tick enable |
| tick_osc | input | 1 | Oscillator tick enable |

## Verification
Two collisions matter most. The first is a rollover landing in the same cycle as a write-one-to-clear of the status flag. The second is a soft-reset write landing in a cycle where the counter would otherwise have advanced. The bench uses its own model to step the counter up to the wrap cycle, then issues the status clear in exactly that cycle; the flag must read back as 1. It also fires a soft reset while the counter runs on the bus clock and expects the counter to read 0 and bit 15 to read 1 for four cycles.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam int BUS_W = 32;

    // word indices within the register window
    localparam logic [3:0] WI_CTRL = 4'd0;
    localparam logic [3:0] WI_PRE  = 4'd1;
    localparam logic [3:0] WI_STAT = 4'd2;
    localparam logic [3:0] WI_CNT  = 4'd9;

    // control field positions
    localparam int CB_EN   = 0;
    localparam int CB_SRC  = 6;
    localparam int CB_FR   = 9;
    localparam int CB_OEN  = 10;
    localparam int CB_SRST = 15;

    // prescaler and status field positions
    localparam int PB_MAIN = 0;
    localparam int PB_OSC  = 12;
    localparam int SB_ROLL = 5;

    // source codes
    localparam logic [2:0] SRC_BUS  = 3'b001;
    localparam logic [2:0] SRC_SLOW = 3'b100;
    localparam logic [2:0] SRC_OSC  = 3'b101;

    typedef enum logic {ST_RUN, ST_SRST} ctl_state_e;
endpackage

// File: rtl/tick_timer_ctl.sv
module tick_timer_ctl
    import tick_timer_pkg::*;
#(
    parameter int SRST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic srst_bit,
    output logic srst_req,
    output logic busy
);
    localparam int HW = (SRST_CYC > 1) ? $clog2(SRST_CYC) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(SRST_CYC - 1);

    ctl_state_e state_q, state_d;
    logic [HW-1:0] hold_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SRST) hold_q <= hold_q + 1'b1;
            else                    hold_q <= '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (ctrl_wr && srst_bit) state_d = ST_SRST;  // RUN_TO_SRST
            ST_SRST: if (hold_q == HOLD_LAST) state_d = ST_RUN;   // SRST_TO_RUN
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        srst_req = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_RUN:  srst_req = ctrl_wr && srst_bit;
            ST_SRST: busy = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tick_timer_src.sv
module tick_timer_src
    import tick_timer_pkg::*;
#(
    parameter int OSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [2:0]       src,
    input  logic             osc_en,
    input  logic [OSC_W-1:0] osc_div,
    input  logic             tick_slow,
    input  logic             tick_osc,
    output logic             raw_tick
);
    logic [OSC_W-1:0] osc_cnt_q;
    logic osc_adv, osc_hit;

    assign osc_adv = en && (src == SRC_OSC) && osc_en && tick_osc;
    assign osc_hit = osc_adv && (osc_cnt_q == osc_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        osc_cnt_q <= '0;
        else if (clr)      osc_cnt_q <= '0;
        else if (osc_hit)  osc_cnt_q <= '0;
        else if (osc_adv)  osc_cnt_q <= osc_cnt_q + 1'b1;
    end

    always_comb begin
        unique case (src)
            SRC_BUS:  raw_tick = 1'b1;
            SRC_SLOW: raw_tick = tick_slow;
            SRC_OSC:  raw_tick = osc_hit;
            default:  raw_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tick_timer_div.sv
module tick_timer_div #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             raw_tick,
    input  logic [DIV_W-1:0] div,
    output logic             cnt_tick
);
    logic [DIV_W-1:0] pcnt_q;
    logic adv;

    assign adv      = en && raw_tick;
    assign cnt_tick = adv && (pcnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pcnt_q <= '0;
        else if (clr)      pcnt_q <= '0;
        else if (cnt_tick) pcnt_q <= '0;
        else if (adv)      pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int              CNT_W      = 32,
    parameter logic [CNT_W-1:0] RESTART_AT = {CNT_W{1'b1}},
    parameter int              MAIN_W     = 12,
    parameter int              OSC_W      = 4,
    parameter int              SRST_CYC   = 4,
    parameter int              ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_slow,
    input  logic              tick_osc
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [3:0] widx;
    logic       ctrl_hit, ctrl_wr, pre_wr, stat_wr;
    logic       srst_req, busy;

    logic             ctrl_en, ctrl_fr, ctrl_oen;
    logic [2:0]       ctrl_src;
    logic [MAIN_W-1:0] main_div;
    logic [OSC_W-1:0]  osc_div;
    logic             flag_q;
    logic [CNT_W-1:0] count_q;

    logic div_clr, sub_clr, raw_tick, cnt_tick, wrap;
    logic [2:0] new_src;

    assign widx     = 4'(bus_addr[ADDR_W-1:2]);
    assign ctrl_hit = bus_wr && (widx == WI_CTRL);
    assign ctrl_wr  = ctrl_hit && !busy;
    assign pre_wr   = bus_wr && (widx == WI_PRE) && !busy;
    assign stat_wr  = bus_wr && (widx == WI_STAT) && !busy;
    assign new_src  = bus_wdata[CB_SRC +: 3];

    tick_timer_ctl #(.SRST_CYC(SRST_CYC)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_hit),
        .srst_bit (bus_wdata[CB_SRST]),
        .srst_req (srst_req),
        .busy     (busy)
    );

    // restart the dividers on enable rise or source change
    assign div_clr = ctrl_wr && !bus_wdata[CB_SRST] &&
                     ((bus_wdata[CB_EN] && !ctrl_en) || (new_src != ctrl_src));
    assign sub_clr = div_clr || srst_req;

    tick_timer_src #(.OSC_W(OSC_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sub_clr),
        .en        (ctrl_en),
        .src       (ctrl_src),
        .osc_en    (ctrl_oen),
        .osc_div   (osc_div),
        .tick_slow (tick_slow),
        .tick_osc  (tick_osc),
        .raw_tick  (raw_tick)
    );

    tick_timer_div #(.DIV_W(MAIN_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sub_clr),
        .en       (ctrl_en),
        .raw_tick (raw_tick),
        .div      (main_div),
        .cnt_tick (cnt_tick)
    );

    // control and prescaler fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_fr  <= 1'b0;
            ctrl_oen <= 1'b0;
            ctrl_src <= '0;
            main_div <= '0;
            osc_div  <= '0;
        end else if (srst_req) begin
            ctrl_en  <= 1'b0;
            ctrl_fr  <= 1'b0;
            ctrl_oen <= 1'b0;
            ctrl_src <= '0;
            main_div <= '0;
            osc_div  <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_en  <= bus_wdata[CB_EN];
                ctrl_fr  <= bus_wdata[CB_FR];
                ctrl_oen <= bus_wdata[CB_OEN];
                ctrl_src <= new_src;
            end
            if (pre_wr) begin
                main_div <= bus_wdata[PB_MAIN +: MAIN_W];
                osc_div  <= bus_wdata[PB_OSC +: OSC_W];
            end
        end
    end

    // counter and rollover flag
    assign wrap = cnt_tick &&
                  ((count_q == CNT_MAX) || (!ctrl_fr && (count_q == RESTART_AT)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        count_q <= '0;
        else if (srst_req) count_q <= '0;
        else if (wrap)     count_q <= '0;
        else if (cnt_tick) count_q <= count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               flag_q <= 1'b0;
        else if (srst_req)                        flag_q <= 1'b0;
        else if (wrap)                            flag_q <= 1'b1;
        else if (stat_wr && bus_wdata[SB_ROLL])   flag_q <= 1'b0;
    end

    // registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= '0;
            unique case (widx)
                WI_CTRL: begin
                    bus_rdata[CB_EN]      <= ctrl_en;
                    bus_rdata[CB_SRC +: 3] <= ctrl_src;
                    bus_rdata[CB_FR]      <= ctrl_fr;
                    bus_rdata[CB_OEN]     <= ctrl_oen;
                    bus_rdata[CB_SRST]    <= busy;
                end
                WI_PRE: begin
                    bus_rdata[PB_MAIN +: MAIN_W] <= main_div;
                    bus_rdata[PB_OSC +: OSC_W]   <= osc_div;
                end
                WI_STAT: bus_rdata[SB_ROLL] <= flag_q;
                WI_CNT:  bus_rdata <= 32'(count_q);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srst_req,
    input logic             busy,
    input logic             ctrl_en,
    input logic [2:0]       ctrl_src,
    input logic [CNT_W-1:0] count_q,
    input logic             flag_q
);
    logic src_ok;
    assign src_ok = (ctrl_src == 3'b001) || (ctrl_src == 3'b100) || (ctrl_src == 3'b101);

    assert_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !srst_req) |=> $stable(count_q));

    assert_bad_src_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !src_ok && !srst_req) |=> $stable(count_q));

    assert_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_req |=> (count_q == $past(count_q)) ||
                      (count_q == CNT_W'($past(count_q) + 1'b1)) || (count_q == '0));

    assert_flag_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_req && count_q != '0) |=> (count_q != '0) || flag_q);

    assert_srst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> (count_q == '0) && !ctrl_en && !flag_q && busy);

    assert_busy_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !srst_req);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst_req (srst_req),
    .busy     (busy),
    .ctrl_en  (ctrl_en),
    .ctrl_src (ctrl_src),
    .count_q  (count_q),
    .flag_q   (flag_q)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 10;
    localparam int CMAX = (1 << CW) - 1;
    localparam int RA  = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic tick_slow = 1'b0, tick_osc = 1'b0;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer #(.CNT_W(CW), .RESTART_AT(CW'(RA))) u_tick_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_slow(tick_slow), .tick_osc(tick_osc)
    );

    // reference model state
    bit m_en, m_fr, m_oen, m_flag;
    bit [2:0] m_src;
    bit [11:0] m_main;
    bit [3:0] m_osc;
    int m_cnt, m_srst, m_op, m_pp;

    function automatic logic [31:0] model_read(input logic [5:0] a);
        case (a[5:2])
            4'd0: return {16'b0, (m_srst > 0), 4'b0, m_oen, m_fr, m_src, 5'b0, m_en};
            4'd1: return {16'b0, m_osc, m_main};
            4'd2: return {26'b0, m_flag, 5'b0};
            4'd9: return 32'(m_cnt);
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_clear();
        m_en = 0; m_fr = 0; m_oen = 0; m_flag = 0; m_src = 0;
        m_main = 0; m_osc = 0; m_cnt = 0; m_op = 0; m_pp = 0;
    endtask

    task automatic model_step(input bit wr, input logic [5:0] a, input logic [31:0] wd,
                              input bit t32, input bit tosc);
        bit raw, inc, wrap;
        int n_op, n_pp, n_cnt;
        if (m_srst > 0) begin m_srst--; return; end
        raw = 0; inc = 0; wrap = 0; n_op = m_op; n_pp = m_pp; n_cnt = m_cnt;
        case (m_src)
            3'b001: raw = 1;
            3'b100: raw = t32;
            3'b101: if (m_en && m_oen && tosc) begin
                        if (m_op == int'(m_osc)) begin raw = 1; n_op = 0; end
                        else n_op = m_op + 1;
                    end
            default: raw = 0;
        endcase
        if (m_en && raw) begin
            if (m_pp == int'(m_main)) begin inc = 1; n_pp = 0; end
            else n_pp = m_pp + 1;
        end
        if (inc) begin
            if (m_cnt == CMAX || (!m_fr && m_cnt == RA)) begin n_cnt = 0; wrap = 1; end
            else n_cnt = m_cnt + 1;
        end
        if (wr && a[5:2] == 4'd0) begin
            if (wd[15]) begin model_clear(); m_srst = 4; return; end
            if ((wd[0] && !m_en) || wd[8:6] != m_src) begin n_op = 0; n_pp = 0; end
            m_en = wd[0]; m_src = wd[8:6]; m_fr = wd[9]; m_oen = wd[10];
        end
        if (wr && a[5:2] == 4'd1) begin m_main = wd[11:0]; m_osc = wd[15:12]; end
        if (wrap) m_flag = 1;
        else if (wr && a[5:2] == 4'd2 && wd[5]) m_flag = 0;
        m_cnt = n_cnt; m_op = n_op; m_pp = n_pp;
    endtask

    // one bus cycle: drive at negedge, compare registered read one cycle later
    task automatic step(input bit wr, input bit rd, input logic [5:0] a, input logic [31:0] wd,
                        input bit t32, input bit tosc, input string tag);
        logic [31:0] exp;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        tick_slow = t32; tick_osc = tosc;
        exp = model_read(a);
        model_step(wr, a, wd, t32, tosc);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        if (rd) begin
            checks++;
            if (bus_rdata !== exp) begin
                fails++;
                $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, a, bus_rdata, exp);
            end
        end
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        step(0, 1, a, 32'h0, 0, 0, tag);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input string tag);
        step(1, 0, a, d, 0, 0, tag);
    endtask

    // idle cycles reading the counter with random tick inputs
    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++)
            step(0, 1, 6'h24, 32'h0, ($urandom % 3) == 0, ($urandom % 2) == 0, tag);
    endtask

    function automatic logic [31:0] ctl(input bit en, input logic [2:0] s, input bit fr, input bit oen);
        return {16'b0, 1'b0, 4'b0, oen, fr, s, 5'b0, en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [2:0] srcs [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b010, 3'b111};
        void'($urandom(32'd20240611));
        model_clear(); m_srst = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int w = 0; w < 10; w++) rd(6'(w * 4), "R1 reset");
        run(4, "R1 idle after reset");

        // R2 map: unused words, field masks
        wr(6'h10, 32'hFFFF_FFFF, "R2");
        rd(6'h10, "R2 unused word");
        wr(6'h24, 32'h0000_0155, "R2");
        rd(6'h24, "R2 counter read-only");
        wr(6'h00, 32'h0000_7FFF, "R2");
        rd(6'h00, "R2 control mask");
        wr(6'h04, 32'hFFFF_FFFF, "R2");
        rd(6'h04, "R2 prescaler mask");
        rd(6'h08, "R2 status mask");
        // R4 invalid code 3'b111 with enable set
        run(6, "R4 invalid source");
        wr(6'h04, 32'h0, "R4");

        // R3 disabled with a valid source
        wr(6'h00, ctl(0, 3'b001, 1, 0), "R3");
        run(8, "R3 disabled");

        // R6 main divider on bus clock, R7 enable rise
        wr(6'h04, 32'h0000_0002, "R6");
        wr(6'h00, ctl(1, 3'b001, 1, 0), "R7");
        run(12, "R6 main divide by 3");
        // R7 source change mid-period
        wr(6'h00, ctl(1, 3'b100, 1, 0), "R7");
        run(12, "R7 slow source after change");
        wr(6'h04, 32'h0, "R4");
        run(12, "R4 slow tick");

        // R5 oscillator gating and pre-divide
        wr(6'h00, ctl(1, 3'b101, 1, 0), "R5");
        run(10, "R5 oscillator path off");
        wr(6'h04, 32'h0000_3000, "R5");
        wr(6'h00, ctl(1, 3'b101, 1, 1), "R5");
        run(24, "R5 oscillator divide by 4");
        wr(6'h04, 32'h0000_2001, "R6");
        run(24, "R6 main after oscillator");

        // R8 free-run wrap on bus clock
        wr(6'h04, 32'h0, "R8");
        wr(6'h00, ctl(1, 3'b001, 1, 0), "R8");
        while (m_cnt != CMAX - 2) step(0, 0, 6'h0, 0, 0, 0, "R8");
        run(5, "R8 free-run wrap");
        rd(6'h08, "R9 flag after wrap");
        wr(6'h08, 32'h0000_0020, "R9");
        rd(6'h08, "R9 flag cleared");

        // R8 restart mode
        wr(6'h00, ctl(1, 3'b001, 0, 0), "R8");
        while (m_cnt != RA - 2) step(0, 0, 6'h0, 0, 0, 0, "R8");
        run(5, "R8 restart at compare");
        wr(6'h08, 32'h0000_0020, "R9");

        // R9 clear coinciding with rollover: set wins
        while (m_cnt != RA) step(0, 0, 6'h0, 0, 0, 0, "R9");
        wr(6'h08, 32'h0000_0020, "R9");
        rd(6'h08, "R9 set beats clear");
        rd(6'h24, "R9 counter after collision");

        // R10 soft reset while counting
        wr(6'h04, 32'h0000_5003, "R10");
        wr(6'h00, 32'h0000_8000 | ctl(1, 3'b001, 1, 0), "R10");
        rd(6'h00, "R10 srst bit 1");
        step(1, 1, 6'h00, ctl(1, 3'b001, 1, 0), 0, 0, "R10 write ignored");
        rd(6'h04, "R10 prescaler zeroed");
        rd(6'h24, "R10 counter zeroed");
        rd(6'h00, "R10 srst bit cleared");
        rd(6'h08, "R10 flag zeroed");
        run(4, "R10 stopped after reset");

        // R11 constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [31:0] d;
            op = $urandom % 20;
            if (op == 0) begin
                d = ctl(($urandom % 4) != 0, srcs[$urandom % 6], $urandom % 2, $urandom % 2);
                if (($urandom % 8) == 0) d[15] = 1'b1;
                step(1, 0, 6'h00, d, $urandom % 2, $urandom % 2, "R11");
            end else if (op == 1) begin
                d = {16'b0, 4'($urandom % 4), 12'($urandom % 4)};
                step(1, 0, 6'h04, d, $urandom % 2, $urandom % 2, "R11");
            end else if (op == 2) begin
                step(1, 0, 6'h08, $urandom, $urandom % 2, $urandom % 2, "R11");
            end else if (op == 3) begin
                step(1, 0, 6'($urandom % 16) << 2, $urandom, 0, 0, "R11");
            end else begin
                step(0, 1, 6'($urandom % 10) << 2, 32'h0, $urandom % 2, $urandom % 2,
                     "R11 random read");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule